// File: doc/BRIEF.md
# Run-of-Three-Ones Detector

This block watches a serial bit stream, one bit per clock, and asserts its output for as long as the most recent three or more samples have all been ones. It is a four-state Moore machine. The output depends only on the registered state, so it is free of glitches and stays stable for the whole cycle. Any zero in the stream clears the run at once. The state register is brought out on a port so that surrounding logic, or a test harness, can see how far the current run has got.

The two state bits can be built from three equivalent flip-flop excitation styles, chosen by a parameter: plain data-type, set/clear (JK) type or toggle type. Each style has its own next-state equations. All three must give the same state sequence and the same output, cycle for cycle. This lets an integrator pick the form that maps best onto the cells available.

Top module: `run3_detect`

## Requirements
- R1: While `rst_n` is low, `state` is 2'b00 and `y` is 0. The reset takes effect at once, without waiting for a clock edge.
- R2: A 0 sampled on `x` at a rising clock edge puts `state` at 2'b00 after that edge, whatever the state was before.
- R3: A 1 sampled on `x` moves `state` one step along 2'b00 → 2'b01 → 2'b10 → 2'b11. These codes stand for zero, one, two and three-or-more consecutive ones.
- R4: In state 2'b11 a further 1 on `x` leaves `state` at 2'b11.
- R5: `y` is 1 exactly when `state` is 2'b11, and is 0 in every other state (Moore output).
- R6: With `STYLE` set to 0 (data flip-flops), 1 (JK flip-flops) or 2 (toggle flip-flops), the `state` and `y` sequences are identical for every input stream.
- R7: `y` rises after the clock edge that samples the third consecutive 1. It stays high while further ones arrive, and falls after the edge that samples the first 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| x | input | 1 | Serial data bit, sampled each rising edge |
| y | output | 1 | High while three or more consecutive ones have been seen |
| state | output | 2 | Current state bits {A,B}: 00, 01, 10, 11 |

## Verification
A wrong next-state term in any one excitation style shows up on `state` at the very next clock edge after the input pattern that uses that term. Its instance then no longer agrees with the other two styles or with the run-length count. A wrong state seen only on the way up the run is caught on `state` at once. It also appears on `y` at most two edges later, when the third one arrives early or late. A reset that is missed or applied late shows as a non-zero `state` while `rst_n` is still low, before any clock edge.

// File: rtl/run3_pkg.sv
package run3_pkg;

    localparam int STYLE_D  = 0;
    localparam int STYLE_JK = 1;
    localparam int STYLE_T  = 2;

    localparam int STATE_W = 2;

    typedef struct packed {
        logic a;
        logic b;
    } ab_t;

    typedef struct packed {
        ab_t  st;
        logic hit;
    } regs_t;

endpackage

// File: rtl/run3_next_d.sv
module run3_next_d
    import run3_pkg::*;
(
    input  ab_t  cur,
    input  logic x,
    output ab_t  nxt
);
    always_comb begin
        nxt.a = (cur.a & x) | (cur.b & x);
        nxt.b = (cur.a & x) | (~cur.b & x);
    end
endmodule

// File: rtl/run3_next_jk.sv
module run3_next_jk
    import run3_pkg::*;
(
    input  ab_t  cur,
    input  logic x,
    output ab_t  nxt
);
    logic ja, ka, jb, kb;

    always_comb begin
        ja = cur.b & x;
        ka = ~x;
        jb = x;
        kb = ~cur.a | ~x;
        nxt.a = (ja & ~cur.a) | (~ka & cur.a);
        nxt.b = (jb & ~cur.b) | (~kb & cur.b);
    end
endmodule

// File: rtl/run3_next_t.sv
module run3_next_t
    import run3_pkg::*;
(
    input  ab_t  cur,
    input  logic x,
    output ab_t  nxt
);
    logic ta, tb;

    always_comb begin
        ta = (cur.a & ~x) | (~cur.a & cur.b & x);
        tb = (~cur.b & x) | (cur.b & ~(cur.a & x));
        nxt.a = ta ^ cur.a;
        nxt.b = tb ^ cur.b;
    end
endmodule

// File: rtl/run3_detect.sv
module run3_detect
    import run3_pkg::*;
#(
    parameter int STYLE = STYLE_D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               x,
    output logic               y,
    output logic [STATE_W-1:0] state
);
    regs_t r_d, r_q;
    ab_t   nxt_st;

    generate
        if (STYLE == STYLE_JK) begin : g_jk
            run3_next_jk u_next (.cur(r_q.st), .x(x), .nxt(nxt_st));
        end else if (STYLE == STYLE_T) begin : g_t
            run3_next_t u_next (.cur(r_q.st), .x(x), .nxt(nxt_st));
        end else begin : g_d
            run3_next_d u_next (.cur(r_q.st), .x(x), .nxt(nxt_st));
        end
    endgenerate

    always_comb begin
        r_d     = r_q;
        r_d.st  = nxt_st;
        r_d.hit = nxt_st.a & nxt_st.b;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign y     = r_q.hit;
    assign state = {r_q.st.a, r_q.st.b};
endmodule

// File: rtl/run3_checker.sv
module run3_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       x,
    input logic       y,
    input logic [1:0] state
);
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |-> (state == 2'b00 && !y));

    a_r2_zero_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !x |=> state == 2'b00);

    a_r3_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (x && state != 2'b11) |=> state == $past(state) + 2'b01);

    a_r4_hold_top: assert property (@(posedge clk) disable iff (!rst_n)
        (x && state == 2'b11) |=> state == 2'b11);

    a_r5_y_matches_state: assert property (@(posedge clk) disable iff (!rst_n)
        y == (state == 2'b11));

    a_r7_rise_after_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y) |-> ($past(state) == 2'b10 && $past(x)));

    a_r7_fall_on_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(y) |-> !$past(x));
endmodule

bind run3_detect run3_checker u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .x     (x),
    .y     (y),
    .state (state)
);

// File: tb/sim_run3_detect.sv
module sim_run3_detect;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       x = 1'b0;
    logic       y0, y1, y2;
    logic [1:0] s0, s1, s2;

    int checks = 0;
    int errors = 0;
    int run = 0;

    always #4 clk = ~clk;

    run3_detect #(.STYLE(0)) u0 (.clk(clk), .rst_n(rst_n), .x(x), .y(y0), .state(s0));
    run3_detect #(.STYLE(1)) u1 (.clk(clk), .rst_n(rst_n), .x(x), .y(y1), .state(s1));
    run3_detect #(.STYLE(2)) u2 (.clk(clk), .rst_n(rst_n), .x(x), .y(y2), .state(s2));

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string tag);
        int es = (run >= 3) ? 3 : run;
        int ey = (run >= 3) ? 1 : 0;
        chk(int'(s0) == es, {tag, " R2/R3/R4 D state"}, int'(s0), es);
        chk(int'(y0) == ey, {tag, " R5/R7 D y"}, int'(y0), ey);
        chk(s1 == s0 && y1 == y0, {tag, " R6 JK vs D"}, int'({y1, s1}), int'({y0, s0}));
        chk(s2 == s0 && y2 == y0, {tag, " R6 T vs D"}, int'({y2, s2}), int'({y0, s0}));
    endtask

    task automatic step(input bit b, input string tag);
        @(negedge clk);
        compare_all(tag);
        x = b;
        run = b ? run + 1 : 0;
    endtask

    initial begin
        bit pat [$];
        #1;
        chk(s0 == 2'b00 && s1 == 2'b00 && s2 == 2'b00, "R1 reset state", int'(s0), 0);
        chk(!y0 && !y1 && !y2, "R1 reset y", int'(y0), 0);
        repeat (2) @(negedge clk);
        chk(s0 == 2'b00 && !y0, "R1 reset held over clocks", int'(s0), 0);
        x = 1'b1;
        @(negedge clk);
        chk(s0 == 2'b00 && s1 == 2'b00 && s2 == 2'b00, "R1 ones ignored in reset", int'(s0), 0);
        x = 1'b0;
        rst_n = 1'b1;
        run = 0;

        pat = '{1, 1, 1, 1, 1, 0, 1, 1, 0, 1, 0, 1, 1, 1, 0, 0, 1, 1, 1, 1, 0};
        foreach (pat[i]) step(pat[i], "directed");

        // climb to the top state, then drop reset between edges (R1 async)
        repeat (4) step(1'b1, "R4 climb");
        @(negedge clk);
        compare_all("R4 top");
        #2 rst_n = 1'b0;
        #1;
        chk(s0 == 2'b00 && s1 == 2'b00 && s2 == 2'b00, "R1 async clear", int'(s2), 0);
        chk(!y0 && !y1 && !y2, "R1 async y", int'(y1), 0);
        x = 1'b0;
        run = 0;
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < 400; i++) begin
            step(($urandom % 4) != 0, "random");
        end
        step(1'b0, "tail");
        step(1'b0, "tail");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule